// File: doc/BRIEF.md
# Linked-List Transmit Descriptor Engine

This block drains a chain of transmit descriptors held in system memory. A descriptor is three consecutive 32-bit words: the address of a packet buffer, a size word, and a pointer to the following descriptor. A start pulse hands the engine the address of the first descriptor. The engine then follows the chain. For each descriptor that holds a packet, it reads the buffer one word at a time and streams the bytes out. It then marks the descriptor as free by writing the size word back with its top bit set, and moves on to the next pointer.

The top bit of the size word has two jobs. Software clears it to hand a descriptor to the engine, and the engine sets it on the way back. A descriptor whose top bit is already set ends the walk. The engine then raises an underrun flag and drops its own busy (enable) state.

The memory side is a single 32-bit master with one outstanding read or write at a time. Each access is held until memory answers. The byte stream has start and end markers and is steered either to the line or to a receive-side loopback lane. Framing, preamble, FCS and the inter-frame gap belong to the next stage.

Top module: `txdesc_dma`

## Requirements
- R1: After reset the engine is idle (`busy_o`=0). It raises no read or write request, presents no byte on either lane, and all status outputs (`sent_count_o`, `sent_flag_o`, `underrun_o`) are zero.
- R2: A `start_i` pulse while idle and with `tx_enable_i`=1 begins the walk at `head_addr_i` with its bits [1:0] forced to 0. With `tx_enable_i`=0 the pulse has no effect: the engine stays idle and issues no memory access.
- R3: For the descriptor at address D, the engine reads D (buffer address), then D+4 (size word), then D+8 (next pointer). In the size word, bit 31 is the empty flag and bits [10:0] are the packet length in bytes (0 to 2047). Bits [30:11] are not part of the length.
- R4: A packet of length L is read from buffer words at B, B+4, and so on. Its bytes leave least significant byte first, exactly L of them. The first byte carries `out_sop_o` and the last carries `out_eop_o`; a one-byte packet carries both. A length of 0 emits no byte.
- R5: After a packet's bytes have left, the engine writes the size word back to D+4 with bit 31 set and all other bits unchanged. It then continues with the descriptor named by the next pointer.
- R6: Each write-back adds one to the 8-bit `sent_count_o` (wrapping) and sets `sent_flag_o`. Both stay set until reset.
- R7: A descriptor whose size word has bit 31 set ends the walk. `underrun_o` becomes 1, `busy_o` falls in the following cycle, and that descriptor gets no byte and no write-back.
- R8: With `loopback_i`=1 (sampled per packet) bytes are qualified by `loop_valid_o`, otherwise by `line_valid_o`. The two are never 1 together. A byte is taken when its valid and `out_ready_i` are both 1, and it is held stable while not taken.
- R9: A `start_i` pulse while `busy_o`=1 is ignored. The walk in progress continues unchanged, and the descriptor given with the ignored pulse is never read or written.
- R10: A read request (`rd_req_o`) stays high with a stable `rd_addr_o` until `rd_valid_i` returns its data. A write request stays high with stable address and data until `wr_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a walk |
| head_addr_i | input | AW | Address of the first descriptor |
| tx_enable_i | input | 1 | Global transmit enable gating `start_i` |
| loopback_i | input | 1 | 1 steers packets to the loopback lane |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | AW | Read address |
| rd_valid_i | input | 1 | Read data returned, ends the read |
| rd_data_i | input | 32 | Read data, little-endian word |
| wr_req_o | output | 1 | Memory write request |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | 32 | Write data |
| wr_ack_i | input | 1 | Write accepted, ends the write |
| out_data_o | output | 8 | Stream byte |
| out_sop_o | output | 1 | First byte of a packet |
| out_eop_o | output | 1 | Last byte of a packet |
| line_valid_o | output | 1 | Byte valid toward the line |
| loop_valid_o | output | 1 | Byte valid toward the receive loopback |
| out_ready_i | input | 1 | Downstream takes the byte |
| busy_o | output | 1 | Walk in progress (the engine's enable) |
| sent_count_o | output | CNT_W | Packets sent, wrapping |
| sent_flag_o | output | 1 | At least one packet sent |
| underrun_o | output | 1 | Walk ended on an empty descriptor |

## Verification
The chain is driven with packet lengths of 6, 1, 0, 4, 9 and 40 bytes. These cover a partial final word, a single byte, an empty payload, an exact word and a multi-word tail. Stalls on `out_ready_i` and a memory that answers after several cycles show whether a byte or a request is dropped or advanced early. A size word with junk above bit 10 separates the length mask from the write-back value. Starting with the enable low, on an already empty head, and a second time during a long packet confirms that the gate, the stop condition and the restart guard leave memory and the stream untouched.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int WORD_BYTES = 4;
  localparam int NB_W = 3;
  localparam int EMPTY_BIT = 31;

  typedef enum logic [2:0] {
    W_IDLE, W_BUFA, W_SIZE, W_LINK, W_DATA, W_EMIT, W_RETIRE
  } walk_e;

  // bytes taken from the next buffer word given the bytes still owed
  function automatic logic [NB_W-1:0] chunk_bytes(input logic [15:0] owed);
    return (owed >= 16'(WORD_BYTES)) ? NB_W'(WORD_BYTES) : NB_W'(owed);
  endfunction

  // size word as stored back after the packet is gone
  function automatic logic [31:0] retire_word(input logic [31:0] sz);
    return sz | (32'd1 << EMPTY_BIT);
  endfunction

  function automatic logic [31:0] word_align(input logic [31:0] a);
    return a & ~32'd3;
  endfunction
endpackage

// File: rtl/txd_serial.sv
module txd_serial
  import txd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_i,
  input  logic [31:0]     word_i,
  input  logic [NB_W-1:0] nb_i,
  input  logic            first_i,
  input  logic            last_i,
  input  logic            ready_i,
  output logic            valid_o,
  output logic [7:0]      data_o,
  output logic            sop_o,
  output logic            eop_o,
  output logic            done_o
);
  logic [31:0]     sh_q;
  logic [NB_W-1:0] left_q;
  logic            sop_q, last_q, vld_q;
  logic            fire;

  assign fire    = vld_q && ready_i;
  assign valid_o = vld_q;
  assign data_o  = sh_q[7:0];
  assign sop_o   = vld_q && sop_q;
  assign eop_o   = vld_q && last_q && (left_q == NB_W'(1));
  assign done_o  = fire && (left_q == NB_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q <= '0; left_q <= '0; sop_q <= 1'b0; last_q <= 1'b0; vld_q <= 1'b0;
    end else if (ld_i) begin
      sh_q <= word_i; left_q <= nb_i; sop_q <= first_i; last_q <= last_i;
      vld_q <= 1'b1;
    end else if (fire) begin
      sh_q   <= sh_q >> 8;
      left_q <= left_q - NB_W'(1);
      sop_q  <= 1'b0;
      if (left_q == NB_W'(1)) vld_q <= 1'b0;
    end
  end

  // R8: an offered byte that is not taken stays put
  p_hold_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && !ready_i |=> vld_q && $stable(data_o) && $stable(sop_o) && $stable(eop_o));
  // R4: a new word is never loaded over bytes still waiting
  p_no_overwrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |-> !vld_q);
endmodule

// File: rtl/txd_walker.sv
module txd_walker
  import txd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [AW-1:0]   head_i,
  input  logic            glob_en_i,
  input  logic            loop_sel_i,
  output logic            rd_req_o,
  output logic [AW-1:0]   rd_addr_o,
  input  logic            rd_valid_i,
  input  logic [31:0]     rd_data_i,
  output logic            wr_req_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [31:0]     wr_data_o,
  input  logic            wr_ack_i,
  output logic            ld_o,
  output logic [31:0]     ld_word_o,
  output logic [NB_W-1:0] ld_nb_o,
  output logic            ld_first_o,
  output logic            ld_last_o,
  input  logic            emit_done_i,
  output logic            loop_q_o,
  output logic            busy_o,
  output logic            pkt_done_o,
  output logic            chain_end_o
);
  walk_e            st;
  logic [AW-1:0]    dptr, bptr, nptr;
  logic [31:0]      szw;
  logic [LEN_W-1:0] owed;
  logic             first_q, loop_q;
  logic             start_acc;

  assign start_acc   = start_i && glob_en_i && (st == W_IDLE);
  assign busy_o      = (st != W_IDLE);
  assign loop_q_o    = loop_q;
  assign rd_req_o    = (st == W_BUFA) || (st == W_SIZE) || (st == W_LINK) || (st == W_DATA);
  assign wr_req_o    = (st == W_RETIRE);
  assign wr_addr_o   = dptr + AW'(4);
  assign wr_data_o   = retire_word(szw);
  assign chain_end_o = (st == W_SIZE) && rd_valid_i && rd_data_i[EMPTY_BIT];
  assign pkt_done_o  = (st == W_RETIRE) && wr_ack_i;
  assign ld_o        = (st == W_DATA) && rd_valid_i;
  assign ld_word_o   = rd_data_i;
  assign ld_nb_o     = chunk_bytes(16'(owed));
  assign ld_first_o  = first_q;
  assign ld_last_o   = (owed <= LEN_W'(WORD_BYTES));

  always_comb begin
    case (st)
      W_SIZE:  rd_addr_o = dptr + AW'(4);
      W_LINK:  rd_addr_o = dptr + AW'(8);
      W_DATA:  rd_addr_o = bptr;
      default: rd_addr_o = dptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= W_IDLE; dptr <= '0; bptr <= '0; nptr <= '0; szw <= '0;
      owed <= '0; first_q <= 1'b0; loop_q <= 1'b0;
    end else begin
      case (st)
        W_IDLE: if (start_acc) begin
          dptr <= AW'(word_align(32'(head_i)));
          st   <= W_BUFA;
        end
        W_BUFA: if (rd_valid_i) begin
          bptr <= AW'(rd_data_i);
          st   <= W_SIZE;
        end
        W_SIZE: if (rd_valid_i) begin
          szw  <= rd_data_i;
          owed <= rd_data_i[LEN_W-1:0];
          st   <= rd_data_i[EMPTY_BIT] ? W_IDLE : W_LINK;
        end
        W_LINK: if (rd_valid_i) begin
          nptr    <= AW'(rd_data_i);
          first_q <= 1'b1;
          loop_q  <= loop_sel_i;
          st      <= (owed == '0) ? W_RETIRE : W_DATA;
        end
        W_DATA: if (rd_valid_i) begin
          owed    <= owed - LEN_W'(ld_nb_o);
          bptr    <= bptr + AW'(WORD_BYTES);
          first_q <= 1'b0;
          st      <= W_EMIT;
        end
        W_EMIT: if (emit_done_i) st <= (owed == '0) ? W_RETIRE : W_DATA;
        W_RETIRE: if (wr_ack_i) begin
          dptr <= nptr;
          st   <= W_BUFA;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  // R2: a start without the global enable leaves the engine idle
  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !glob_en_i && !busy_o |=> !busy_o);
  // R2: the first access of a walk is word aligned
  p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> rd_req_o && (rd_addr_o[1:0] == 2'b00));
  // R7: stopping on an empty descriptor drops busy next cycle
  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chain_end_o |=> !busy_o && !wr_req_o);
  // R9: a start during a walk does not move the descriptor pointer
  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && busy_o && !pkt_done_o |=> $stable(dptr));
endmodule

// File: rtl/txd_status.sv
module txd_status #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_done_i,
  input  logic             chain_end_i,
  output logic [CNT_W-1:0] count_o,
  output logic             sent_o,
  output logic             under_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o <= '0; sent_o <= 1'b0; under_o <= 1'b0;
    end else begin
      if (pkt_done_i) begin
        count_o <= count_o + CNT_W'(1);
        sent_o  <= 1'b1;
      end
      if (chain_end_i) under_o <= 1'b1;
    end
  end

  // R6: each retired packet advances the count by one
  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done_i |=> count_o == CNT_W'($past(count_o) + CNT_W'(1)) && sent_o);
  // R7: the underrun flag rises only on a chain end
  p_under_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(under_o) |-> $past(chain_end_i));
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
  import txd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 11,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [AW-1:0]    head_addr_i,
  input  logic             tx_enable_i,
  input  logic             loopback_i,
  output logic             rd_req_o,
  output logic [AW-1:0]    rd_addr_o,
  input  logic             rd_valid_i,
  input  logic [31:0]      rd_data_i,
  output logic             wr_req_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [31:0]      wr_data_o,
  input  logic             wr_ack_i,
  output logic [7:0]       out_data_o,
  output logic             out_sop_o,
  output logic             out_eop_o,
  output logic             line_valid_o,
  output logic             loop_valid_o,
  input  logic             out_ready_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] sent_count_o,
  output logic             sent_flag_o,
  output logic             underrun_o
);
  logic            ld, ld_first, ld_last, emit_done, loop_q, byte_vld;
  logic [31:0]     ld_word;
  logic [NB_W-1:0] ld_nb;
  logic            pkt_done, chain_end;

  txd_walker #(.AW(AW), .LEN_W(LEN_W)) u_walk (
    .clk, .rst_n, .start_i, .head_i(head_addr_i), .glob_en_i(tx_enable_i),
    .loop_sel_i(loopback_i), .rd_req_o, .rd_addr_o, .rd_valid_i, .rd_data_i,
    .wr_req_o, .wr_addr_o, .wr_data_o, .wr_ack_i,
    .ld_o(ld), .ld_word_o(ld_word), .ld_nb_o(ld_nb), .ld_first_o(ld_first),
    .ld_last_o(ld_last), .emit_done_i(emit_done), .loop_q_o(loop_q),
    .busy_o, .pkt_done_o(pkt_done), .chain_end_o(chain_end)
  );

  txd_serial u_ser (
    .clk, .rst_n, .ld_i(ld), .word_i(ld_word), .nb_i(ld_nb),
    .first_i(ld_first), .last_i(ld_last), .ready_i(out_ready_i),
    .valid_o(byte_vld), .data_o(out_data_o), .sop_o(out_sop_o),
    .eop_o(out_eop_o), .done_o(emit_done)
  );

  txd_status #(.CNT_W(CNT_W)) u_stat (
    .clk, .rst_n, .pkt_done_i(pkt_done), .chain_end_i(chain_end),
    .count_o(sent_count_o), .sent_o(sent_flag_o), .under_o(underrun_o)
  );

  assign line_valid_o = byte_vld && !loop_q;
  assign loop_valid_o = byte_vld && loop_q;

  // R8: at most one lane is offered a byte
  p_one_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({line_valid_o, loop_valid_o}));
  // R10: read request held with a stable address until answered
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o));
  // R10: write request held with stable address and data until acknowledged
  p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));
  // R5: every write-back marks the descriptor empty
  p_retire_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> wr_data_o[31]);
  // R1: nothing is requested or offered while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !rd_req_o && !wr_req_o && !line_valid_o && !loop_valid_o);
endmodule

// File: tb/sim_txdesc_dma.sv
module sim_txdesc_dma;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, tx_enable_i = 0, loopback_i = 0;
  logic [31:0] head_addr_i = '0;
  logic rd_req_o, wr_req_o, rd_valid_i = 0, wr_ack_i = 0;
  logic [31:0] rd_addr_o, rd_data_i = '0, wr_addr_o, wr_data_o;
  logic [7:0] out_data_o;
  logic out_sop_o, out_eop_o, line_valid_o, loop_valid_o, out_ready_i = 1;
  logic busy_o, sent_flag_o, underrun_o;
  logic [7:0] sent_count_o;

  txdesc_dma u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  logic [31:0] mem [0:255];
  int n_chk = 0, n_fail = 0;
  int n_reads, n_writes, addr_flips, n_got, lat, rd_cd, wr_cd;
  logic [31:0] rd_log [0:63];
  logic [31:0] wr_log [0:15];
  logic [7:0]  got_b [0:255];
  logic        got_s [0:255], got_e [0:255], got_l [0:255];
  logic [7:0]  exp_b [0:255];
  int n_exp;
  logic rd_busy = 0, wr_busy = 0, stall_en = 0;
  logic [31:0] rd_a;
  int stall_ctr = 0;
  logic done_flag = 0;

  // memory: answers reads after lat extra cycles, one access at a time
  always @(negedge clk) begin
    if (rd_valid_i) begin rd_valid_i = 0; rd_busy = 0; end
    else if (rd_req_o) begin
      if (!rd_busy) begin
        rd_busy = 1; rd_cd = lat; rd_a = rd_addr_o;
        if (n_reads < 64) rd_log[n_reads] = rd_addr_o;
        n_reads++;
      end else if (rd_addr_o != rd_a) addr_flips++;
      if (rd_cd == 0) begin rd_valid_i = 1; rd_data_i = mem[rd_a[9:2]]; end
      else rd_cd--;
    end
    if (wr_ack_i) begin wr_ack_i = 0; wr_busy = 0; end
    else if (wr_req_o) begin
      if (!wr_busy) begin wr_busy = 1; wr_cd = lat; end
      if (wr_cd == 0) begin
        wr_ack_i = 1; mem[wr_addr_o[9:2]] = wr_data_o;
        if (n_writes < 16) wr_log[n_writes] = wr_addr_o;
        n_writes++;
      end else wr_cd--;
    end
  end

  // byte sink: ready pattern set here, byte recorded when it will be taken
  always @(negedge clk) begin
    stall_ctr++;
    out_ready_i = !(stall_en && (stall_ctr % 3 == 0));
    if ((line_valid_o || loop_valid_o) && out_ready_i && n_got < 256) begin
      got_b[n_got] = out_data_o; got_s[n_got] = out_sop_o;
      got_e[n_got] = out_eop_o;  got_l[n_got] = loop_valid_o;
      n_got++;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; start_i = 0; tx_enable_i = 1; loopback_i = 0; stall_en = 0;
    n_reads = 0; n_writes = 0; addr_flips = 0; n_got = 0; n_exp = 0; lat = 0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'(i * 7 + seed * 31 + 3);
  endfunction

  // place a buffer and append its bytes to the expected list
  task automatic put_buf(input int b, input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      mem[(b + i) >> 2][8*((b + i) & 3) +: 8] = pat(i, seed);
      exp_b[n_exp] = pat(i, seed); n_exp++;
    end
  endtask

  task automatic put_desc(input int d, input int b, input logic [31:0] sz, input int nx);
    mem[d >> 2] = 32'(b); mem[(d + 4) >> 2] = sz; mem[(d + 8) >> 2] = 32'(nx);
  endtask

  task automatic pulse_start(input logic [31:0] h);
    @(negedge clk); head_addr_i = h; start_i = 1;
    @(negedge clk); start_i = 0;
  endtask

  task automatic wait_idle();
    int k = 0;
    repeat (3) @(negedge clk);
    while (busy_o && k < 20000) begin @(negedge clk); k++; end
    chk(k < 20000, "walk did not end", 32'(k), 32'd20000);
    repeat (3) @(negedge clk);
  endtask

  function automatic int mism();
    int m = 0;
    for (int i = 0; i < n_exp; i++) if (i >= n_got || got_b[i] !== exp_b[i]) m++;
    return m;
  endfunction

  function automatic int count_marks(input logic want_sop);
    int c = 0;
    for (int i = 0; i < n_got; i++) c += int'(want_sop ? got_s[i] : got_e[i]);
    return c;
  endfunction

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk(!busy_o && !rd_req_o && !wr_req_o, "R1 idle after reset", {busy_o, rd_req_o, wr_req_o}, 0);
    chk(sent_count_o == 0 && !sent_flag_o && !underrun_o, "R1 status zero",
        {sent_count_o, sent_flag_o, underrun_o}, 0);
    chk(!line_valid_o && !loop_valid_o, "R1 no byte", {line_valid_o, loop_valid_o}, 0);
  endtask

  task automatic t_no_enable();
    do_reset();
    tx_enable_i = 0;
    put_desc(32'hC0, 32'h2C0, 32'd5, 32'hD0);
    pulse_start(32'hC0);
    repeat (30) @(negedge clk);
    chk(!busy_o && n_reads == 0, "R2 start gated by enable", 32'(n_reads), 0);
    chk(n_got == 0, "R2 no bytes without enable", 32'(n_got), 0);
  endtask

  task automatic t_single();
    do_reset();
    put_buf(32'h100, 6, 1);
    put_desc(32'h10, 32'h100, 32'h0000_7806, 32'h40);
    put_desc(32'h40, 32'h300, 32'h8000_0000, 32'h0);
    pulse_start(32'h13);
    wait_idle();
    chk(rd_log[0] == 32'h10, "R2 head aligned", rd_log[0], 32'h10);
    chk(rd_log[1] == 32'h14 && rd_log[2] == 32'h18, "R3 descriptor word order",
        {rd_log[1][15:0], rd_log[2][15:0]}, 32'h0014_0018);
    chk(rd_log[3] == 32'h100 && rd_log[4] == 32'h104, "R4 buffer words",
        {rd_log[3][15:0], rd_log[4][15:0]}, 32'h0100_0104);
    chk(n_got == 6, "R3 length from low 11 bits", 32'(n_got), 6);
    chk(mism() == 0, "R4 bytes LSB first", 32'(mism()), 0);
    chk(got_s[0] && got_e[5] && count_marks(1) == 1 && count_marks(0) == 1,
        "R4 sop/eop placement", 32'(count_marks(1)), 1);
    chk(!got_l[0] && !got_l[5], "R8 line lane when loopback off", {got_l[0], got_l[5]}, 0);
    chk(mem[32'h14 >> 2] == 32'h8000_7806, "R5 write-back value", mem[32'h14 >> 2], 32'h8000_7806);
    chk(n_reads == 7 && rd_log[5] == 32'h40, "R5 follows next pointer", rd_log[5], 32'h40);
    chk(sent_count_o == 1 && sent_flag_o, "R6 count and flag", 32'(sent_count_o), 1);
    chk(underrun_o && !busy_o && n_writes == 1, "R7 stop on empty", 32'(n_writes), 1);
  endtask

  task automatic t_chain();
    int lane_err = 0;
    do_reset();
    loopback_i = 1; stall_en = 1; lat = 2;
    put_buf(32'h180, 1, 2);
    put_buf(32'h1C0, 4, 3);
    put_buf(32'h200, 9, 4);
    put_desc(32'h20, 32'h180, 32'd1, 32'h50);
    put_desc(32'h50, 32'h1A0, 32'd0, 32'h60);
    put_desc(32'h60, 32'h1C0, 32'd4, 32'h70);
    put_desc(32'h70, 32'h200, 32'd9, 32'h90);
    put_desc(32'h90, 32'h0, 32'h8000_0000, 32'h0);
    pulse_start(32'h20);
    wait_idle();
    for (int i = 0; i < n_got; i++) if (!got_l[i]) lane_err++;
    chk(n_got == 14, "R4 byte total with zero-length packet", 32'(n_got), 14);
    chk(mism() == 0, "R4 chained bytes", 32'(mism()), 0);
    chk(count_marks(1) == 3 && count_marks(0) == 3 && got_s[0] && got_e[0],
        "R4 markers, one-byte packet both", 32'(count_marks(0)), 3);
    chk(lane_err == 0, "R8 loopback lane only", 32'(lane_err), 0);
    chk(sent_count_o == 4, "R6 four packets counted", 32'(sent_count_o), 4);
    chk(mem[32'h54 >> 2] == 32'h8000_0000 && mem[32'h74 >> 2] == 32'h8000_0009,
        "R5 all descriptors retired", mem[32'h74 >> 2], 32'h8000_0009);
    chk(n_writes == 4 && mem[32'h94 >> 2] == 32'h8000_0000, "R7 empty tail untouched",
        32'(n_writes), 4);
    chk(addr_flips == 0, "R10 address stable while waiting", 32'(addr_flips), 0);
  endtask

  task automatic t_restart();
    int other_reads = 0;
    do_reset();
    stall_en = 1; lat = 3;
    put_buf(32'h240, 40, 5);
    put_desc(32'hA0, 32'h240, 32'd40, 32'hB0);
    put_desc(32'hB0, 32'h0, 32'h8000_0000, 32'h0);
    put_desc(32'hC0, 32'h2C0, 32'd5, 32'hD0);
    put_desc(32'hD0, 32'h0, 32'h8000_0000, 32'h0);
    pulse_start(32'hA0);
    repeat (10) @(negedge clk);
    chk(busy_o, "R9 engine busy before second start", 32'(busy_o), 1);
    pulse_start(32'hC0);
    wait_idle();
    for (int i = 0; i < n_reads && i < 64; i++) if (rd_log[i] >= 32'hC0 && rd_log[i] < 32'hCC) other_reads++;
    chk(n_got == 40 && mism() == 0, "R9 first walk unchanged", 32'(n_got), 40);
    chk(other_reads == 0 && mem[32'hC4 >> 2] == 32'd5, "R9 ignored descriptor untouched",
        mem[32'hC4 >> 2], 32'd5);
    chk(sent_count_o == 1, "R9 one packet only", 32'(sent_count_o), 1);
  endtask

  task automatic t_empty_head();
    do_reset();
    put_desc(32'hD0, 32'h0, 32'h8000_0003, 32'h0);
    pulse_start(32'hD0);
    wait_idle();
    chk(underrun_o && !busy_o, "R7 underrun on empty head", {underrun_o, busy_o}, 32'b10);
    chk(n_got == 0 && n_writes == 0 && n_reads == 2, "R7 no data, no write-back",
        32'(n_reads), 2);
    chk(sent_count_o == 0 && !sent_flag_o, "R6 no count on empty", 32'(sent_count_o), 0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_no_enable();
    t_single();
    t_chain();
    t_restart();
    t_empty_head();
    finish_run();
  end
endmodule